// File: doc/BRIEF.md
# Ordered Fragment Reorder Unit

This unit puts results back into arrival order after ordered work items have gone to several workers. Each item gets a sequence number from a small window when it is handed out. A worker then returns completions tagged with that sequence number. Each completion may store a payload (a fragment), close the sequence number, or do both. A plain forward is one fragment together with its close. Up to sixteen fragments can arrive for one sequence number. The unit buffers them and emits them on a ready/valid stream. The oldest sequence number goes first, and each sequence number's fragments keep the order in which they were sent.

The window holds eight outstanding sequence numbers. When all eight are outstanding, new numbers are refused. The oldest slot may stream out its stored fragments while the worker is still producing more. The window moves past it only after its close has been seen and every stored fragment has left. A fragment beyond the per-slot limit is discarded, and a sticky error flag is raised. The slot count must be a power of two.

Top module: `ofr_reorder_unit`

## Requirements
- R1: After reset, sequence numbers are issued as 0, 1, 2, ... and wrap modulo the slot count (8). A number is taken in a cycle where `alloc_req` and `alloc_ok` are both high. `alloc_seq` shows the number the next request will get.
- R2: While 8 sequence numbers are outstanding, `alloc_ok` is low and a request takes no number: `alloc_seq` does not change. `alloc_ok` returns high once the oldest slot has retired.
- R3: Fragments of different sequence numbers leave in allocation order, whatever order their completions arrive in.
- R4: Fragments of one sequence number leave in the order their completions arrived. Each carries that number on `out_seq`.
- R5: A slot accepts up to 16 fragments, and all 16 are emitted.
- R6: A 17th or later fragment for a slot is dropped. `frag_err` goes high and stays high until reset.
- R7: A completion with `cpl_frag`=1 and `cpl_close`=1 (forward) stores its payload and closes the slot in one step. `cpl_frag`=1, `cpl_close`=0 is a fragment only. `cpl_frag`=0, `cpl_close`=1 is a release.
- R8: The oldest slot emits its stored fragments before its close arrives. No fragment of any later slot is emitted until the oldest slot has been closed and drained.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_seq` and `out_data` hold.
- R10: A slot closed with no fragments emits nothing, and the window moves past it.
- R11: A completion to a sequence number that is not outstanding has no effect. Its payload is never emitted.
- R12: After reset, `out_valid`=0, `alloc_ok`=1, `alloc_seq`=0 and `frag_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request a sequence number |
| alloc_ok | output | 1 | A sequence number is free this cycle |
| alloc_seq | output | 3 | Sequence number the next request receives |
| cpl_valid | input | 1 | Completion present |
| cpl_seq | input | 3 | Sequence number of the completion |
| cpl_frag | input | 1 | Completion carries a payload to store |
| cpl_close | input | 1 | Completion closes its slot |
| cpl_data | input | 32 | Completion payload |
| out_valid | output | 1 | Output fragment valid |
| out_ready | input | 1 | Consumer accepts the output fragment |
| out_seq | output | 3 | Sequence number of the output fragment |
| out_data | output | 32 | Output fragment payload |
| frag_err | output | 1 | Sticky: a fragment was dropped for exceeding the slot limit |

## Verification
The bench sends completions in scrambled orders, for example the youngest slot's forward before the oldest one's. A unit that emitted in completion order would put a late fragment ahead of an earlier slot's output. It fills one slot with seventeen fragments: a one-off limit would either lose the sixteenth fragment or let the seventeenth through, and a non-sticky flag would be seen cleared later. It holds the oldest slot open while a younger slot is already complete. A head that moved early would emit the younger fragments during the wait. Two more cases cover a full window with back-pressure, where a design that counted wrongly would hand out a ninth number or change its output while stalled, and a stray completion to a free slot, whose payload must never show up.

// File: rtl/ofr_pkg.sv
package ofr_pkg;
  localparam int unsigned OFR_SLOTS_DEF  = 8;
  localparam int unsigned OFR_FRAGS_DEF  = 16;
  localparam int unsigned OFR_DATA_W_DEF = 32;
endpackage

// File: rtl/ofr_frag_ram.sv
module ofr_frag_ram #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/ofr_slot_table.sv
module ofr_slot_table #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned FRAGS = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              alloc_req,
  output logic                              alloc_ok,
  output logic [$clog2(SLOTS)-1:0]          alloc_seq,
  input  logic                              cpl_valid,
  input  logic [$clog2(SLOTS)-1:0]          cpl_seq,
  input  logic                              cpl_frag,
  input  logic                              cpl_close,
  output logic                              wr_en,
  output logic [$clog2(SLOTS)+$clog2(FRAGS)-1:0] wr_addr,
  input  logic                              pop,
  output logic                              avail,
  output logic [$clog2(SLOTS)-1:0]          head_seq,
  output logic [$clog2(SLOTS)+$clog2(FRAGS)-1:0] rd_addr,
  output logic                              frag_err
);
  localparam int unsigned SEQ_W  = $clog2(SLOTS);
  localparam int unsigned FIDX_W = $clog2(FRAGS);
  localparam int unsigned CNT_W  = $clog2(FRAGS + 1);
  localparam int unsigned OCC_W  = $clog2(SLOTS + 1);

  logic [SLOTS-1:0] busy;
  logic [SLOTS-1:0] closed;
  logic [CNT_W-1:0] wcnt [SLOTS];

  logic [SEQ_W-1:0] head, tail;
  logic [OCC_W-1:0] occ;
  logic [CNT_W-1:0] rcnt;
  logic             err_q;

  logic grant, hit, room, ovf, retire;

  assign alloc_ok  = (occ != OCC_W'(SLOTS));
  assign grant     = alloc_req & alloc_ok;
  assign alloc_seq = tail;

  assign hit     = cpl_valid & busy[cpl_seq] & ~closed[cpl_seq];
  assign room    = (wcnt[cpl_seq] != CNT_W'(FRAGS));
  assign wr_en   = hit & cpl_frag & room;
  assign ovf     = hit & cpl_frag & ~room;
  assign wr_addr = {cpl_seq, wcnt[cpl_seq][FIDX_W-1:0]};

  assign avail    = busy[head] & (rcnt != wcnt[head]);
  assign retire   = busy[head] & closed[head] & (rcnt == wcnt[head]);
  assign rd_addr  = {head, rcnt[FIDX_W-1:0]};
  assign head_seq = head;
  assign frag_err = err_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic             b_q, c_q;
    logic [CNT_W-1:0] n_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        b_q <= 1'b0;
        c_q <= 1'b0;
        n_q <= '0;
      end else if (retire && head == SEQ_W'(g)) begin
        b_q <= 1'b0;
        c_q <= 1'b0;
        n_q <= '0;
      end else begin
        if (grant && tail == SEQ_W'(g)) b_q <= 1'b1;
        if (hit && cpl_seq == SEQ_W'(g)) begin
          if (wr_en)     n_q <= n_q + 1'b1;
          if (cpl_close) c_q <= 1'b1;
        end
      end
    end

    assign busy[g]   = b_q;
    assign closed[g] = c_q;
    assign wcnt[g]   = n_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      occ   <= '0;
      rcnt  <= '0;
      err_q <= 1'b0;
    end else begin
      if (retire) head <= head + 1'b1;
      if (grant)  tail <= tail + 1'b1;
      occ <= occ + OCC_W'(grant) - OCC_W'(retire);
      if (retire)   rcnt <= '0;
      else if (pop) rcnt <= rcnt + 1'b1;
      if (ovf) err_q <= 1'b1;
    end
  end

  a_r2_occ_bound: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(SLOTS));

  a_r1_seq_step: assert property (@(posedge clk) disable iff (rst)
    alloc_req && alloc_ok |=> alloc_seq == SEQ_W'($past(alloc_seq) + 1'b1));

  a_r8_head_waits: assert property (@(posedge clk) disable iff (rst)
    busy[head] && !closed[head] |=> head_seq == $past(head_seq));

  a_r5_read_behind_write: assert property (@(posedge clk) disable iff (rst)
    busy[head] |-> (rcnt <= wcnt[head]) && (wcnt[head] <= CNT_W'(FRAGS)));

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    frag_err |=> frag_err);
endmodule

// File: rtl/ofr_out_stage.sv
module ofr_out_stage #(
  parameter int unsigned SEQ_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             avail,
  input  logic [SEQ_W-1:0] head_seq,
  input  logic             out_ready,
  output logic             pop,
  output logic             out_valid,
  output logic [SEQ_W-1:0] out_seq
);
  assign pop = avail & (~out_valid | out_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_seq   <= '0;
    end else if (pop) begin
      out_valid <= 1'b1;
      out_seq   <= head_seq;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r9_hold_seq: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_seq));
endmodule

// File: rtl/ofr_reorder_unit.sv
module ofr_reorder_unit
  import ofr_pkg::*;
#(
  parameter int unsigned SLOTS  = OFR_SLOTS_DEF,
  parameter int unsigned FRAGS  = OFR_FRAGS_DEF,
  parameter int unsigned DATA_W = OFR_DATA_W_DEF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc_req,
  output logic                     alloc_ok,
  output logic [$clog2(SLOTS)-1:0] alloc_seq,
  input  logic                     cpl_valid,
  input  logic [$clog2(SLOTS)-1:0] cpl_seq,
  input  logic                     cpl_frag,
  input  logic                     cpl_close,
  input  logic [DATA_W-1:0]        cpl_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [$clog2(SLOTS)-1:0] out_seq,
  output logic [DATA_W-1:0]        out_data,
  output logic                     frag_err
);
  localparam int unsigned SEQ_W  = $clog2(SLOTS);
  localparam int unsigned ADDR_W = SEQ_W + $clog2(FRAGS);

  logic              wr_en, avail, pop;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [SEQ_W-1:0]  head_seq;

  ofr_slot_table #(.SLOTS(SLOTS), .FRAGS(FRAGS)) u_table (
    .clk       (clk),
    .rst       (rst),
    .alloc_req (alloc_req),
    .alloc_ok  (alloc_ok),
    .alloc_seq (alloc_seq),
    .cpl_valid (cpl_valid),
    .cpl_seq   (cpl_seq),
    .cpl_frag  (cpl_frag),
    .cpl_close (cpl_close),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .pop       (pop),
    .avail     (avail),
    .head_seq  (head_seq),
    .rd_addr   (rd_addr),
    .frag_err  (frag_err)
  );

  ofr_frag_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (cpl_data),
    .rd_en   (pop),
    .rd_addr (rd_addr),
    .rd_data (out_data)
  );

  ofr_out_stage #(.SEQ_W(SEQ_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .avail     (avail),
    .head_seq  (head_seq),
    .out_ready (out_ready),
    .pop       (pop),
    .out_valid (out_valid),
    .out_seq   (out_seq)
  );

  a_r9_hold_data: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> $stable(out_data));
endmodule

// File: tb/test_ofr_reorder_unit.sv
module test_ofr_reorder_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        alloc_req = 1'b0;
  logic        alloc_ok;
  logic [2:0]  alloc_seq;
  logic        cpl_valid = 1'b0;
  logic [2:0]  cpl_seq = '0;
  logic        cpl_frag = 1'b0;
  logic        cpl_close = 1'b0;
  logic [31:0] cpl_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_seq;
  logic [31:0] out_data;
  logic        frag_err;

  always #4 clk = ~clk;

  ofr_reorder_unit i_ofr_reorder_unit (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_ok(alloc_ok),
    .alloc_seq(alloc_seq), .cpl_valid(cpl_valid), .cpl_seq(cpl_seq),
    .cpl_frag(cpl_frag), .cpl_close(cpl_close), .cpl_data(cpl_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_seq(out_seq),
    .out_data(out_data), .frag_err(frag_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int rdy_mode = 0;
  logic [34:0] exp_q [$];
  string tag_q [$];
  logic [2:0] bseq = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input logic [2:0] s, input logic [31:0] d, input string req);
    exp_q.push_back({s, d});
    tag_q.push_back(req);
  endtask

  task automatic do_alloc(output logic [2:0] s);
    @(negedge clk);
    alloc_req = 1'b1;
    #1;
    chk(alloc_ok === 1'b1 && alloc_seq === bseq, "R1", {alloc_ok, alloc_seq}, {1'b1, bseq});
    s = alloc_seq;
    @(negedge clk);
    alloc_req = 1'b0;
    bseq = bseq + 3'd1;
  endtask

  task automatic send(input logic [2:0] s, input bit f, input bit c, input logic [31:0] d);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_seq = s; cpl_frag = f; cpl_close = c; cpl_data = d;
    @(negedge clk);
    cpl_valid = 1'b0; cpl_frag = 1'b0; cpl_close = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 600 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    #2;
    chk(exp_q.size() == 0 && out_valid === 1'b0, req, {exp_q.size(), out_valid}, 0);
  endtask

  // ready driver
  initial begin
    logic [15:0] lfsr = 16'hACE1;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: out_ready = lfsr[0] | lfsr[3];
        default: out_ready = 1'b0;
      endcase
    end
  end

  // monitor / scoreboard
  initial begin
    bit held_v = 1'b0;
    logic [34:0] held = '0;
    forever begin
      @(negedge clk);
      #2;
      if (!rst) begin
        if (held_v)
          chk(out_valid === 1'b1 && {out_seq, out_data} === held, "R9",
              {out_valid, out_seq, out_data}, {1'b1, held});
        held_v = 1'b0;
        if (out_valid && !out_ready) begin
          held_v = 1'b1;
          held = {out_seq, out_data};
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3 unexpected output", {out_seq, out_data}, 0);
          end else begin
            logic [34:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({out_seq, out_data} === e, t, {out_seq, out_data}, e);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] sa, sb, sc, sd, se, sf, sg, sh;
    logic [2:0] sx;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R12 reset state
    chk(out_valid === 1'b0, "R12", out_valid, 0);
    chk(alloc_ok === 1'b1, "R12", alloc_ok, 1);
    chk(alloc_seq === 3'd0, "R12", alloc_seq, 0);
    chk(frag_err === 1'b0, "R12", frag_err, 0);

    // R3/R4/R7: A, B (three fragments), C completed out of order
    rdy_mode = 1;
    do_alloc(sa); do_alloc(sb); do_alloc(sc);
    push(sa, 32'hA000_0001, "R7");
    push(sb, 32'hB000_0001, "R4");
    push(sb, 32'hB000_0002, "R4");
    push(sb, 32'hB000_0003, "R4");
    push(sc, 32'hC000_0001, "R3");
    send(sc, 1, 1, 32'hC000_0001);
    send(sb, 1, 0, 32'hB000_0001);
    send(sb, 1, 0, 32'hB000_0002);
    send(sa, 1, 1, 32'hA000_0001);
    send(sb, 1, 0, 32'hB000_0003);
    send(sb, 0, 1, 32'hDEAD_0000);
    drain("R3");

    // R10: empty release on older slot
    do_alloc(sd); do_alloc(se);
    push(se, 32'hE000_0001, "R10");
    send(se, 1, 1, 32'hE000_0001);
    send(sd, 0, 1, 32'h0);
    drain("R10");

    // R5/R6: 17 fragments into one slot
    do_alloc(sf);
    for (int i = 0; i < 16; i++) push(sf, 32'hF000_0000 + i, "R5");
    for (int i = 0; i < 16; i++) send(sf, 1, 0, 32'hF000_0000 + i);
    chk(frag_err === 1'b0, "R6", frag_err, 0);
    send(sf, 1, 0, 32'hF000_0BAD);
    chk(frag_err === 1'b1, "R6", frag_err, 1);
    send(sf, 0, 1, 32'h0);
    drain("R5");

    // R8: head drains early, younger slot waits
    rdy_mode = 0;
    do_alloc(sg); do_alloc(sh);
    push(sg, 32'h6000_0001, "R8");
    send(sh, 1, 0, 32'h7000_0001);
    send(sh, 0, 1, 32'h0);
    send(sg, 1, 0, 32'h6000_0001);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #2;
      if (i > 4) chk(out_valid === 1'b0 && exp_q.size() == 0, "R8", out_valid, 0);
    end
    push(sh, 32'h7000_0001, "R8");
    send(sg, 0, 1, 32'h0);
    drain("R8");
    chk(frag_err === 1'b1, "R6 sticky", frag_err, 1);

    // R2: full window with back-pressure
    for (int i = 0; i < 8; i++) begin
      logic [2:0] t;
      do_alloc(t);
    end
    @(negedge clk);
    alloc_req = 1'b1;
    #1;
    chk(alloc_ok === 1'b0, "R2", alloc_ok, 0);
    @(negedge clk);
    alloc_req = 1'b0;
    #1;
    chk(alloc_seq === bseq && alloc_ok === 1'b0, "R2", {alloc_ok, alloc_seq}, {1'b0, bseq});
    rdy_mode = 2;
    for (int i = 0; i < 8; i++) push(3'(bseq + 3'(i)), 32'h5500_0000 + i, "R3");
    for (int i = 7; i >= 0; i--) send(3'(bseq + 3'(i)), 1, 1, 32'h5500_0000 + i);
    rdy_mode = 1;
    drain("R2");
    #1;
    chk(alloc_ok === 1'b1, "R2", alloc_ok, 1);

    // R11: completion to a free slot is ignored
    rdy_mode = 0;
    sx = bseq + 3'd3;
    send(sx, 1, 1, 32'h1111_DEAD);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #2;
      chk(out_valid === 1'b0, "R11", out_valid, 0);
    end
    for (int i = 0; i < 4; i++) begin
      logic [2:0] t;
      do_alloc(t);
    end
    push(sx, 32'h2222_0001, "R11");
    send(sx, 1, 1, 32'h2222_0001);
    for (int i = 0; i < 3; i++) send(3'(sx - 3'd3 + 3'(i)), 0, 1, 32'h0);
    drain("R11");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule